// File: doc/BRIEF.md
# Four-channel aligned pulse-width modulator

This block drives four pulse-width modulated outputs from one system clock. A shared clock generator supplies thirteen count rates. Eleven of them come from a free-running binary prescaler, at the system clock divided by 1, 2, 4 and so on up to 1024. Two more come from linear dividers, each of which divides one chosen prescaler rate by an 8-bit integer. Every channel picks one of these thirteen rates and advances its own 16-bit counter at that rate.

A channel compares its counter with a duty value to produce its output. The counter can run as a sawtooth, which gives a left-aligned pulse, or as a triangle, which gives a center-aligned pulse. The output polarity can be inverted. Software changes period and duty through an update register. While the channel runs, the new value waits in a shadow register and is applied at the end of the current period, so a period never mixes old and new settings. Each period end raises a sticky per-channel interrupt flag.

Software talks to the block through a write-only register port. Channel i has a mode word at address 4+2i and an update word at address 5+2i.

Top module: `pwm_array`

## Requirements
- R1: After reset every bit of pwm_o and irq_o is 0 and all channels are stopped.
- R2: Clock select value k in the range 0 to 10, held in mode bits [3:0], advances the channel counter once every 2^k clock cycles.
- R3: Select values 11 and 12 pick linear divider A or B. Both are set by a write to address 0: A takes its divisor from bits [7:0] and its prescaler tap from bits [11:8], and B takes its divisor from bits [23:16] and its tap from bits [27:24]. A divider ticks once every divisor * 2^tap cycles, and a divisor of 0 stops it.
- R4: With mode bit 4 at 0 (left aligned), the counter steps 0, 1, ... up to the period value and then returns to 0, so one output period lasts period+1 ticks.
- R5: With mode bit 4 at 1 (center aligned), the counter rises to the period value and then falls back to 0, so one output period lasts 2*period ticks.
- R6: A running channel drives 1 while its counter is below the duty value and 0 otherwise. Mode bit 5 inverts this. A stopped channel drives its inactive level: 0, or 1 when inverted.
- R7: Writing 1 to bit i at address 1 starts channel i with its counter at 0. Writing 1 to bit i at address 2 stops it. Other channels are not affected.
- R8: An update word carries the value in bits [15:0] and a target in bit 16 (1 = period, 0 = duty). On a running channel the value takes effect at the next period end. On a stopped channel it takes effect at once.
- R9: Every period end sets irq_o[i]. Writing 1 to bit i at address 3 clears it, and a flag that is being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | 4 | Modulated output of each channel |
| irq_o | output | 4 | Sticky period-end flag of each channel |

## Verification
The waveform checks compare the outputs cycle by cycle against a sawtooth model and a triangle model, one of them with inverted polarity. A short left-aligned period tells an off-by-one wrap apart from a correct one. The triangle period shows whether the turning points are counted twice. A mid-period update of both period and duty must leave the first period untouched and reshape the second, which separates buffered from immediate loading. The rate checks measure high time and period on channels fed by a prescaler tap and by each linear divider, then stop a divider and expect no edges at all.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  // register addresses
  localparam int ADR_CLKCFG = 0;
  localparam int ADR_START  = 1;
  localparam int ADR_STOP   = 2;
  localparam int ADR_ACK    = 3;
  localparam int ADR_CHBASE = 4;   // mode at base+2i, update at base+2i+1

  // field positions
  localparam int POS_DIV_A  = 0;
  localparam int POS_TAP_A  = 8;
  localparam int POS_DIV_B  = 16;
  localparam int POS_TAP_B  = 24;
  localparam int TAP_W      = 4;
  localparam int POS_CENTER = 4;
  localparam int POS_INVERT = 5;

  typedef enum logic {ALIGN_EDGE = 1'b0, ALIGN_MID = 1'b1} align_e;

  // output level from comparison result and polarity
  function automatic logic drive_level(input logic running, input logic below,
                                       input logic invert);
    return running ? (below ^ invert) : invert;
  endfunction
endpackage

// File: rtl/pwm_lindiv.sv
`timescale 1ns/1ps
module pwm_lindiv #(
  parameter int PRE_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int TAP_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRE_TAPS-1:0] taps,
  input  logic [TAP_W-1:0]    tap_sel,
  input  logic [DIV_W-1:0]    divisor,
  output logic                tick_o
);
  logic             src_tick;
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  always_comb begin
    src_tick = 1'b0;
    for (int i = 0; i < PRE_TAPS; i++)
      if (tap_sel == TAP_W'(i)) src_tick = taps[i];
  end

  assign at_end = (cnt_q >= divisor - 1'b1);
  assign tick_o = src_tick && (divisor != '0) && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (divisor == '0)    cnt_q <= '0;
    else if (src_tick)         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  AST_LIN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && divisor > DIV_W'(1)) |=> !tick_o); // R3
endmodule

// File: rtl/pwm_clkgen.sv
`timescale 1ns/1ps
module pwm_clkgen #(
  parameter int PRE_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int TAP_W    = 4,
  localparam int NUM_SRC = PRE_TAPS + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div_a,
  input  logic [TAP_W-1:0]   tap_a,
  input  logic [DIV_W-1:0]   div_b,
  input  logic [TAP_W-1:0]   tap_b,
  output logic [NUM_SRC-1:0] ticks
);
  logic [PRE_TAPS-2:0] pre_q;
  logic [PRE_TAPS-1:0] pre_tick;
  logic                lin_a, lin_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign pre_tick[0] = 1'b1;
  for (genvar k = 1; k < PRE_TAPS; k++) begin : g_tap
    assign pre_tick[k] = &pre_q[k-1:0];
    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick[k] |-> pre_tick[k-1]); // R2
    AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick[k] |=> !pre_tick[k]); // R2
  end

  pwm_lindiv #(.PRE_TAPS(PRE_TAPS), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_div_a (
    .clk(clk), .rst_n(rst_n), .taps(pre_tick), .tap_sel(tap_a),
    .divisor(div_a), .tick_o(lin_a));
  pwm_lindiv #(.PRE_TAPS(PRE_TAPS), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_div_b (
    .clk(clk), .rst_n(rst_n), .taps(pre_tick), .tap_sel(tap_b),
    .divisor(div_b), .tick_o(lin_b));

  assign ticks = {lin_b, lin_a, pre_tick};
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan #(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 13,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_ticks,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  input  logic               ack_cmd,
  input  logic               mode_we,
  input  logic [SEL_W-1:0]   mode_sel,
  input  logic               mode_center,
  input  logic               mode_invert,
  input  logic               upd_we,
  input  logic               upd_period,
  input  logic [CNT_W-1:0]   upd_val,
  output logic               pwm_o,
  output logic               irq_o,
  output logic               period_end_o
);
  import pwm_pkg::*;

  logic [SEL_W-1:0] sel_q;
  align_e           align_q;
  logic             inv_q, run_q, down_q, irq_q;
  logic [CNT_W-1:0] cnt_q, per_q, duty_q, per_shadow, duty_shadow;
  logic             per_pend, duty_pend;
  logic             rate_tick, adv;
  logic [CNT_W+1:0] nx;
  logic             nx_wrap, nx_down;
  logic [CNT_W-1:0] nx_cnt;

  // one counter step: returns {wrap, down, count}
  function automatic logic [CNT_W+1:0] step(input logic [CNT_W-1:0] c,
      input logic dn, input logic mid, input logic [CNT_W-1:0] p);
    logic [CNT_W-1:0] nc;
    logic nd, w;
    nc = c; nd = 1'b0; w = 1'b0;
    if (!mid) begin
      if (c >= p) begin nc = '0; w = 1'b1; end
      else nc = c + 1'b1;
    end else if (!dn) begin
      if (c >= p) begin
        if (c <= CNT_W'(1)) begin nc = '0; w = 1'b1; end
        else begin nc = c - 1'b1; nd = 1'b1; end
      end else nc = c + 1'b1;
    end else begin
      if (c <= CNT_W'(1)) begin nc = '0; w = 1'b1; end
      else begin nc = c - 1'b1; nd = 1'b1; end
    end
    return {w, nd, nc};
  endfunction

  always_comb begin
    rate_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_q == SEL_W'(i)) rate_tick = src_ticks[i];
  end

  assign adv          = run_q && rate_tick;
  assign nx           = step(cnt_q, down_q, align_q == ALIGN_MID, per_q);
  assign nx_wrap      = nx[CNT_W+1];
  assign nx_down      = nx[CNT_W];
  assign nx_cnt       = nx[CNT_W-1:0];
  assign period_end_o = adv && nx_wrap;
  assign pwm_o        = drive_level(run_q, cnt_q < duty_q, inv_q);
  assign irq_o        = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; align_q <= ALIGN_EDGE; inv_q <= 1'b0;
    end else if (mode_we) begin
      sel_q <= mode_sel; inv_q <= mode_invert;
      align_q <= mode_center ? ALIGN_MID : ALIGN_EDGE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; cnt_q <= '0; down_q <= 1'b0;
    end else if (start_cmd) begin
      run_q <= 1'b1; cnt_q <= '0; down_q <= 1'b0;
    end else if (stop_cmd) begin
      run_q <= 1'b0; cnt_q <= '0; down_q <= 1'b0;
    end else if (adv) begin
      cnt_q <= nx_cnt; down_q <= nx_down;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0; duty_q <= '0; per_shadow <= '0; duty_shadow <= '0;
      per_pend <= 1'b0; duty_pend <= 1'b0;
    end else begin
      if (period_end_o) begin
        if (per_pend)  per_q  <= per_shadow;
        if (duty_pend) duty_q <= duty_shadow;
        per_pend <= 1'b0; duty_pend <= 1'b0;
      end
      if (upd_we && !run_q) begin
        if (upd_period) per_q <= upd_val;
        else            duty_q <= upd_val;
      end else if (upd_we) begin
        if (upd_period) begin per_shadow <= upd_val; per_pend <= 1'b1; end
        else begin duty_shadow <= upd_val; duty_pend <= 1'b1; end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            irq_q <= 1'b0;
    else if (period_end_o) irq_q <= 1'b1;
    else if (ack_cmd)      irq_q <= 1'b0;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= per_q); // R4
  AST_DOWN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    down_q |-> cnt_q != '0); // R5
  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0 && pwm_o == inv_q)); // R7
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !period_end_o) |=> ($stable(per_q) && $stable(duty_q))); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> irq_o); // R9
endmodule

// File: rtl/pwm_array.sv
`timescale 1ns/1ps
module pwm_array #(
  parameter int N_CH     = 4,
  parameter int CNT_W    = 16,
  parameter int PRE_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_CH-1:0]   pwm_o,
  output logic [N_CH-1:0]   irq_o
);
  import pwm_pkg::*;

  localparam int NUM_SRC = PRE_TAPS + 2;
  localparam int SEL_W   = $clog2(NUM_SRC);

  logic [DIV_W-1:0]   div_a_q, div_b_q;
  logic [TAP_W-1:0]   tap_a_q, tap_b_q;
  logic [NUM_SRC-1:0] ticks;
  logic [N_CH-1:0]    period_end;
  logic               wr_start, wr_stop, wr_ack;

  assign wr_start = wr_en && wr_addr == ADDR_W'(ADR_START);
  assign wr_stop  = wr_en && wr_addr == ADDR_W'(ADR_STOP);
  assign wr_ack   = wr_en && wr_addr == ADDR_W'(ADR_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a_q <= '0; tap_a_q <= '0; div_b_q <= '0; tap_b_q <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(ADR_CLKCFG)) begin
      div_a_q <= wr_data[POS_DIV_A +: DIV_W];
      tap_a_q <= wr_data[POS_TAP_A +: TAP_W];
      div_b_q <= wr_data[POS_DIV_B +: DIV_W];
      tap_b_q <= wr_data[POS_TAP_B +: TAP_W];
    end
  end

  pwm_clkgen #(.PRE_TAPS(PRE_TAPS), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .div_a(div_a_q), .tap_a(tap_a_q),
    .div_b(div_b_q), .tap_b(tap_b_q), .ticks(ticks));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic mode_hit, upd_hit;
    assign mode_hit = wr_en && wr_addr == ADDR_W'(ADR_CHBASE + 2*i);
    assign upd_hit  = wr_en && wr_addr == ADDR_W'(ADR_CHBASE + 2*i + 1);

    pwm_chan #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .src_ticks(ticks),
      .start_cmd(wr_start && wr_data[i]),
      .stop_cmd(wr_stop && wr_data[i]),
      .ack_cmd(wr_ack && wr_data[i]),
      .mode_we(mode_hit),
      .mode_sel(wr_data[SEL_W-1:0]),
      .mode_center(wr_data[POS_CENTER]),
      .mode_invert(wr_data[POS_INVERT]),
      .upd_we(upd_hit),
      .upd_period(wr_data[CNT_W]),
      .upd_val(wr_data[CNT_W-1:0]),
      .pwm_o(pwm_o[i]),
      .irq_o(irq_o[i]),
      .period_end_o(period_end[i]));
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0)); // R1
  AST_FLAG_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o[0]) |-> $past(period_end[0]))); // R9
endmodule

// File: tb/pwm_array_tb.sv
`timescale 1ns/1ps
module pwm_array_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  pwm_o, irq_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    int    at;
    int    ch;
    bit    is_flag;
    bit    want;
    string req;
  } exp_item_t;
  exp_item_t sb[$];

  always #2.5 clk = ~clk;

  pwm_array u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .pwm_o(pwm_o), .irq_o(irq_o));

  // reference waveforms restated from the requirements
  function automatic bit ref_edge(int n, int p, int d);
    return (n % (p + 1)) < d;
  endfunction
  function automatic bit ref_mid(int n, int p, int d);
    int m, c;
    m = n % (2 * p);
    c = (m <= p) ? m : 2 * p - m;
    return c < d;
  endfunction

  task automatic check(input bit got, input bit want, input string req, input string what);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s %s got=%0b exp=%0b", req, what, got, want);
    end
  endtask

  task automatic check_int(input int got, input int want, input string req, input string what);
    checks++;
    if (got != want) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, want);
    end
  endtask

  // driver: one register write; cap is the sample index right after capture
  task automatic wr(input int a, input logic [31:0] d, output int cap);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
    cap = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int at, input int ch, input bit is_flag, input bit want,
                      input string req);
    exp_item_t it;
    it.at = at; it.ch = ch; it.is_flag = is_flag; it.want = want; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  // monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          check(sb[i].is_flag ? irq_o[sb[i].ch] : pwm_o[sb[i].ch], sb[i].want,
                sb[i].req, $sformatf("ch%0d %s cyc%0d", sb[i].ch,
                sb[i].is_flag ? "flag" : "out", cyc));
          sb.delete(i);
        end else if (sb[i].at < cyc) begin
          sb.delete(i);
        end
      end
    end
  end

  // measures high time and period of one output, in cycles
  task automatic measure(input int ch, output int hi, output int per);
    int t, t_rise, t_fall;
    bit prev, now;
    t = 0; t_rise = -1; t_fall = -1; hi = -1; per = -1;
    @(posedge clk); #1; prev = pwm_o[ch];
    while (t < 20000) begin
      @(posedge clk); #1; t++;
      now = pwm_o[ch];
      if (!prev && now) begin
        if (t_rise < 0) t_rise = t;
        else if (t_fall >= 0) begin per = t - t_rise; hi = t_fall - t_rise; break; end
      end
      if (prev && !now && t_rise >= 0) t_fall = t;
      prev = now;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c, base, hi, per, edges;
    bit prev;
    repeat (3) @(negedge clk);
    check_int(int'(pwm_o), 0, "R1", "outputs in reset");
    check_int(int'(irq_o), 0, "R1", "flags in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_int(int'(pwm_o), 0, "R1", "outputs after reset");

    // R4 R8: channel 0 left aligned, loaded while stopped, then reshaped mid-period
    wr(4, 32'h0, c);
    wr(5, (32'h1 << 16) | 9, c);
    wr(5, 32'd3, c);
    wr(3, 32'hF, c);
    wr(1, 32'h1, base);
    for (int n = 1; n < 30; n++)
      push(base + n, 0, 1'b0, (n < 10) ? ref_edge(n, 9, 3) : ref_edge(n - 10, 4, 2),
           (n < 10) ? "R4" : "R8");
    push(base + 9, 0, 1'b1, 1'b0, "R9");
    push(base + 10, 0, 1'b1, 1'b1, "R9");
    wr(5, (32'h1 << 16) | 4, c);
    wr(5, 32'd2, c);
    drain();
    wr(2, 32'h1, c);  // R7: stop channel 0
    for (int n = 1; n < 6; n++) push(c + n, 0, 1'b0, 1'b0, "R7");
    drain();

    // R5 R6: channel 1 center aligned, inverted
    wr(6, (32'h1 << 4) | (32'h1 << 5), c);
    wr(7, (32'h1 << 16) | 5, c);
    wr(7, 32'd2, c);
    check(pwm_o[1], 1'b1, "R6", "stopped inverted level");
    wr(3, 32'hF, c);
    wr(1, 32'h2, base);
    for (int n = 1; n < 40; n++) push(base + n, 1, 1'b0, !ref_mid(n, 5, 2), "R5");
    push(base + 9, 1, 1'b1, 1'b0, "R9");
    push(base + 10, 1, 1'b1, 1'b1, "R9");
    // R7: restart channel 0 while channel 1 keeps running
    wr(1, 32'h1, c);
    for (int n = 1; n < 13; n++) push(c + n, 0, 1'b0, ref_edge(n, 4, 2), "R7");
    repeat (14) @(negedge clk);
    wr(2, 32'h1, c);
    for (int n = 1; n < 4; n++) push(c + n, 0, 1'b0, 1'b0, "R7");
    drain();

    wr(2, 32'hF, c);
    wr(3, 32'hF, c);
    @(negedge clk);
    check_int(int'(irq_o), 0, "R9", "flags after clear");
    check(pwm_o[1], 1'b1, "R6", "inverted level after stop");

    // R2: prescaler taps on channel 2, period 3 duty 2
    wr(8, 32'd2, c);
    wr(9, (32'h1 << 16) | 3, c);
    wr(9, 32'd2, c);
    wr(1, 32'h4, c);
    measure(2, hi, per);
    check_int(per, 16, "R2", "tap2 period");
    check_int(hi, 8, "R2", "tap2 high");
    wr(2, 32'h4, c);
    wr(8, 32'd5, c);
    wr(1, 32'h4, c);
    measure(2, hi, per);
    check_int(per, 128, "R2", "tap5 period");
    check_int(hi, 64, "R2", "tap5 high");
    wr(2, 32'h4, c);

    // R3: linear dividers on channel 3
    wr(0, 32'd3 | (32'd1 << 8) | (32'd1 << 16), c);
    wr(10, 32'd11, c);
    wr(11, (32'h1 << 16) | 3, c);
    wr(11, 32'd2, c);
    wr(1, 32'h8, c);
    measure(3, hi, per);
    check_int(per, 24, "R3", "divider A period");
    check_int(hi, 12, "R3", "divider A high");
    wr(10, 32'd12, c);
    measure(3, hi, per);
    check_int(per, 4, "R3", "divider B period");
    check_int(hi, 2, "R3", "divider B high");
    wr(10, 32'd11, c);
    wr(0, 32'd1 << 16, c);
    repeat (10) @(negedge clk);
    edges = 0;
    prev = pwm_o[3];
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (pwm_o[3] != prev) edges++;
      prev = pwm_o[3];
    end
    check_int(edges, 0, "R3", "divider off edges");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule